// File: doc/BRIEF.md
# Bunch-Train Hit Timestamp Buffer

This block sits behind the binary discriminators of a pixel sensor that has no trigger and operates in bunch trains. While a train is active it keeps a running collision number. On every collision strobe it captures the discriminator word, with one bit per pixel. It then writes one record for each firing pixel into a local hit store. A record holds the pixel address and the collision number. The store is sized to hold a whole train.

After the train closes, the block drains the store in write order over a valid/ready stream. It then emits a closing marker that carries the number of stored records and an overflow indication. Hits that arrive once the store is full are dropped and never disturb stored records. A new train must not begin before the marker has been taken. If it does, the block raises a sticky sequencing error and starts acquiring again.

Top module: `train_hit_buffer`

## Requirements
- R1: After reset, out_valid, out_marker and seq_err are all 0 and the block is idle.
- R2: The first accepted strobe after train_start is tagged with collision number 0. Each further accepted strobe is tagged one higher. The number saturates at 2^TS_W-1 (16383 with the default TS_W = 14), so it covers at least 0 to 13999.
- R3: The firing pixels of one strobe are written one record per cycle in ascending pixel-address order. Every record of that strobe carries the same collision number. The next strobe may come NUM_PIX+1 cycles after the previous one.
- R4: Once DEPTH records are stored, further hits are dropped. The DEPTH stored records are read back unchanged, and the marker shows out_count = DEPTH and out_ovf = 1.
- R5: train_start clears the overflow indication. The marker of a following train without a dropped hit shows out_ovf = 0.
- R6: A strobe outside the acquiring phase writes nothing. For example, a strobe during readout leaves the record count and the stored records unchanged.
- R7: train_end starts readout once all captured hits are written. Records then appear in write order, and out_marker = 0 for them. While out_valid is high and out_ready is low, the outputs hold steady.
- R8: After the last record, one marker beat is sent with out_valid = 1 and out_marker = 1. It carries out_count = number of stored records and out_ovf. Taking the marker returns the block to idle.
- R9: train_start during readout or marker sets seq_err. The flag stays set until reset, and acquisition restarts with an empty store.
- R10: A train with no hits produces only the marker, with out_count = 0 and out_ovf = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Begin a train: clear counter, store and overflow |
| train_end | input | 1 | Close the train and move to readout |
| coll_strobe | input | 1 | One pulse per collision |
| pix_hit | input | NUM_PIX | Discriminator outputs, bit n = pixel n |
| out_ready | input | 1 | Downstream accepts the current beat |
| out_valid | output | 1 | A record or marker beat is offered |
| out_marker | output | 1 | Current beat is the end-of-train marker |
| out_pix | output | clog2(NUM_PIX) | Pixel address of the record |
| out_ts | output | TS_W | Collision number of the record |
| out_count | output | clog2(DEPTH+1) | Stored record count (valid on marker) |
| out_ovf | output | 1 | A hit was dropped this train (valid on marker) |
| seq_err | output | 1 | Sticky: train began before readout finished |

## Verification
The capture path is driven with a sequence of hit words. The sequence contains empty words, single low and high pixels, sparse mixed words and the all-ones word. Together these show whether ordering, per-strobe tagging and skipping of silent collisions are right. A readout with a stalling ready separates correct hold behaviour from lost or repeated beats. A train of all-ones words run past capacity shows whether the dropped hits leave the stored records intact. Long runs of empty strobes reach collision numbers 14000 and the saturation value. Further trains cover the empty train and a restart during readout.

// File: rtl/thb_pkg.sv
package thb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACQ   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_MARK  = 2'd3
   } thb_state_e;
endpackage

// File: rtl/thb_coll_ctr.sv
// Saturating collision-number counter.
module thb_coll_ctr #(
   parameter int TS_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            step,
   output logic [TS_W-1:0] value
);
   localparam logic [TS_W-1:0] TS_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                      value <= '0;
      else if (clear)                  value <= '0;
      else if (step && value != TS_MAX) value <= value + 1'b1;
   end
endmodule

// File: rtl/thb_prio_pick.sv
// Picks the lowest set request bit.
module thb_prio_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
   end
endmodule

// File: rtl/thb_hit_store.sv
// Record memory with fill count and drop flag.
module thb_hit_store #(
   parameter int DEPTH = 64,
   parameter int PIX_W = 3,
   parameter int TS_W  = 14,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [PIX_W-1:0]  wr_pix,
   input  logic [TS_W-1:0]   wr_ts,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [PIX_W-1:0]  rd_pix,
   output logic [TS_W-1:0]   rd_ts,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   logic [PIX_W-1:0] mem_pix [DEPTH];
   logic [TS_W-1:0]  mem_ts  [DEPTH];
   logic             full;

   assign full = (count == CNT_W'(DEPTH));

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_en && !full && !clear && count == CNT_W'(e)) begin
            mem_pix[e] <= wr_pix;
            mem_ts[e]  <= wr_ts;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (clear) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (wr_en) begin
         if (full) ovf   <= 1'b1;
         else      count <= count + 1'b1;
      end
   end

   assign rd_pix = mem_pix[rd_idx];
   assign rd_ts  = mem_ts[rd_idx];
endmodule

// File: rtl/train_hit_buffer.sv
module train_hit_buffer #(
   parameter int NUM_PIX = 8,
   parameter int DEPTH   = 64,
   parameter int TS_W    = 14,
   localparam int PIX_W  = $clog2(NUM_PIX),
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               train_start,
   input  logic               train_end,
   input  logic               coll_strobe,
   input  logic [NUM_PIX-1:0] pix_hit,
   input  logic               out_ready,
   output logic               out_valid,
   output logic               out_marker,
   output logic [PIX_W-1:0]   out_pix,
   output logic [TS_W-1:0]    out_ts,
   output logic [CNT_W-1:0]   out_count,
   output logic               out_ovf,
   output logic               seq_err
);
   import thb_pkg::*;

   if (NUM_PIX < 2) begin : g_bad_pix
      $fatal(1, "NUM_PIX must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $fatal(1, "DEPTH must be at least 2");
   end
   if (TS_W < 14 || TS_W > 31) begin : g_bad_ts
      $fatal(1, "TS_W must lie in 14..31");
   end

   thb_state_e         state;
   logic [NUM_PIX-1:0] pending;
   logic [TS_W-1:0]    pend_ts;
   logic               end_req;
   logic [CNT_W-1:0]   rd_ptr;
   logic [TS_W-1:0]    coll_num;
   logic               pick_any;
   logic [PIX_W-1:0]   pick_idx;
   logic [PIX_W-1:0]   rd_pix;
   logic [TS_W-1:0]    rd_ts;
   logic [CNT_W-1:0]   count;
   logic               ovf;
   logic               strobe_ok;
   logic               wr_en;
   logic               drain_busy;

   assign strobe_ok  = (state == ST_ACQ) && !end_req && coll_strobe && !pick_any && !train_start;
   assign wr_en      = (state == ST_ACQ) && pick_any && !train_start;
   assign drain_busy = (state == ST_DRAIN) || (state == ST_MARK);

   thb_coll_ctr #(.TS_W(TS_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (train_start),
      .step  (strobe_ok),
      .value (coll_num)
   );

   thb_prio_pick #(.N(NUM_PIX), .IW(PIX_W)) u_pick (
      .req (pending),
      .any (pick_any),
      .idx (pick_idx)
   );

   thb_hit_store #(.DEPTH(DEPTH), .PIX_W(PIX_W), .TS_W(TS_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (train_start),
      .wr_en  (wr_en),
      .wr_pix (pick_idx),
      .wr_ts  (pend_ts),
      .rd_idx (rd_ptr[ADDR_W-1:0]),
      .rd_pix (rd_pix),
      .rd_ts  (rd_ts),
      .count  (count),
      .ovf    (ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pending <= '0;
         pend_ts <= '0;
         end_req <= 1'b0;
         rd_ptr  <= '0;
         seq_err <= 1'b0;
      end else if (train_start) begin
         state   <= ST_ACQ;
         pending <= '0;
         end_req <= 1'b0;
         rd_ptr  <= '0;
         if (drain_busy) seq_err <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: ;
            ST_ACQ: begin
               if (strobe_ok) begin
                  pending <= pix_hit;
                  pend_ts <= coll_num;
               end else if (pick_any) begin
                  pending <= pending & ~(NUM_PIX'(1) << pick_idx);
               end
               if (train_end) end_req <= 1'b1;
               if (end_req && !pick_any) begin
                  state  <= ST_DRAIN;
                  rd_ptr <= '0;
               end
            end
            ST_DRAIN: begin
               if (rd_ptr == count)  state  <= ST_MARK;
               else if (out_ready)   rd_ptr <= rd_ptr + 1'b1;
            end
            ST_MARK: begin
               if (out_ready) begin
                  state   <= ST_IDLE;
                  end_req <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      out_valid  = 1'b0;
      out_marker = 1'b0;
      out_pix    = '0;
      out_ts     = '0;
      if (state == ST_DRAIN && rd_ptr != count) begin
         out_valid = 1'b1;
         out_pix   = rd_pix;
         out_ts    = rd_ts;
      end else if (state == ST_MARK) begin
         out_valid  = 1'b1;
         out_marker = 1'b1;
      end
   end

   assign out_count = count;
   assign out_ovf   = ovf;
endmodule

// File: rtl/thb_checker.sv
module thb_checker #(
   parameter int NUM_PIX = 8,
   parameter int DEPTH   = 64,
   parameter int TS_W    = 14,
   localparam int PIX_W  = $clog2(NUM_PIX),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             train_start,
   input logic             out_ready,
   input logic             out_valid,
   input logic             out_marker,
   input logic [PIX_W-1:0] out_pix,
   input logic [TS_W-1:0]  out_ts,
   input logic [CNT_W-1:0] out_count,
   input logic             out_ovf,
   input logic             seq_err
);
   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !seq_err));

   assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !train_start) |=>
         (out_valid && $stable(out_marker) && $stable(out_pix) && $stable(out_ts)));

   assert_marker_is_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_marker |-> out_valid);

   assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_marker |-> (out_count <= CNT_W'(DEPTH)));

   assert_record_implies_stored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_marker) |-> (out_count != '0));

   assert_ovf_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(train_start) |-> !out_ovf);

   assert_seq_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);
endmodule

bind train_hit_buffer thb_checker #(.NUM_PIX(NUM_PIX), .DEPTH(DEPTH), .TS_W(TS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .train_start (train_start),
   .out_ready   (out_ready),
   .out_valid   (out_valid),
   .out_marker  (out_marker),
   .out_pix     (out_pix),
   .out_ts      (out_ts),
   .out_count   (out_count),
   .out_ovf     (out_ovf),
   .seq_err     (seq_err)
);

// File: tb/train_hit_buffer_tb.sv
module train_hit_buffer_tb;
   localparam int NUM_PIX = 8;
   localparam int DEPTH   = 64;
   localparam int TS_W    = 14;
   localparam int NVEC    = 12;
   localparam logic [NUM_PIX-1:0] VEC [NVEC] = '{
      8'h00, 8'h01, 8'h80, 8'hA5, 8'hFF, 8'h00,
      8'h3C, 8'h81, 8'h10, 8'h5A, 8'h02, 8'h00 };

   logic clk = 1'b0;
   logic rst_n, train_start, train_end, coll_strobe, out_ready;
   logic [NUM_PIX-1:0] pix_hit;
   logic out_valid, out_marker, out_ovf, seq_err;
   logic [2:0] out_pix;
   logic [TS_W-1:0] out_ts;
   logic [6:0] out_count;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   int exp_pix [128];
   int exp_ts  [128];
   int exp_n;
   int exp_ovf;
   int got_pix [128];
   int got_ts  [128];
   int got_n;
   int mk_count;
   int mk_ovf;
   bit got_mark;

   always #10 clk = ~clk;

   train_hit_buffer #(.NUM_PIX(NUM_PIX), .DEPTH(DEPTH), .TS_W(TS_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
      .coll_strobe(coll_strobe), .pix_hit(pix_hit), .out_ready(out_ready),
      .out_valid(out_valid), .out_marker(out_marker), .out_pix(out_pix),
      .out_ts(out_ts), .out_count(out_count), .out_ovf(out_ovf), .seq_err(seq_err));

   task automatic chk_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); train_start = 1'b1;
      @(negedge clk); train_start = 1'b0;
      exp_n = 0; exp_ovf = 0;
   endtask

   task automatic pulse_end();
      @(negedge clk); train_end = 1'b1;
      @(negedge clk); train_end = 1'b0;
   endtask

   task automatic add_hits(input logic [NUM_PIX-1:0] p, input int ts);
      for (int b = 0; b < NUM_PIX; b++) begin
         if (p[b]) begin
            if (exp_n < DEPTH) begin
               exp_pix[exp_n] = b; exp_ts[exp_n] = ts; exp_n++;
            end else exp_ovf = 1;
         end
      end
   endtask

   task automatic strobe(input logic [NUM_PIX-1:0] p, input int gap);
      @(negedge clk); coll_strobe = 1'b1; pix_hit = p;
      @(negedge clk); coll_strobe = 1'b0; pix_hit = '0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic drain(input bit stall);
      int guard;
      guard = 0; got_n = 0; got_mark = 0;
      while (!got_mark && guard < 5000) begin
         @(negedge clk);
         guard++;
         out_ready = stall ? (guard % 3 != 1) : 1'b1;
         if (out_valid && out_ready) begin
            if (out_marker) begin
               mk_count = out_count; mk_ovf = out_ovf; got_mark = 1;
            end else if (got_n < 128) begin
               got_pix[got_n] = out_pix; got_ts[got_n] = out_ts; got_n++;
            end
         end
      end
      @(negedge clk); out_ready = 1'b0;
      chk_eq("R8 marker seen", int'(got_mark), 1);
   endtask

   task automatic compare(input string req);
      chk_eq({req, " record count"}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         chk_eq({req, " R3 pixel order"}, got_pix[i], exp_pix[i]);
         chk_eq({req, " R2 timestamp"}, got_ts[i], exp_ts[i]);
      end
      chk_eq({req, " R8 marker count"}, mk_count, exp_n);
      chk_eq({req, " marker ovf"}, mk_ovf, exp_ovf);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      rst_n = 1'b0; train_start = 1'b0; train_end = 1'b0;
      coll_strobe = 1'b0; pix_hit = '0; out_ready = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_eq("R1 out_valid", int'(out_valid), 0);
      chk_eq("R1 out_marker", int'(out_marker), 0);
      chk_eq("R1 seq_err", int'(seq_err), 0);

      // R6: strobe while idle is ignored
      strobe(8'hFF, NUM_PIX + 1);
      chk_eq("R6 idle strobe no output", int'(out_valid), 0);

      // Vector table: one strobe per entry, collision number = index
      pulse_start();
      for (int v = 0; v < NVEC; v++) begin
         add_hits(VEC[v], v);
         strobe(VEC[v], NUM_PIX + 1);
      end
      pulse_end();
      repeat (2) @(negedge clk);
      strobe(8'hFF, 2);   // R6: strobe during readout writes nothing
      drain(1'b1);        // R7 stalled readout
      compare("R7 vectors");
      chk_eq("R8 back to idle", int'(out_valid), 0);

      // R10 empty train
      pulse_start();
      pulse_end();
      drain(1'b0);
      compare("R10 empty");

      // R4 overflow: 9 all-ones strobes, 72 hits into 64 entries
      pulse_start();
      for (int v = 0; v < 9; v++) begin
         add_hits(8'hFF, v);
         strobe(8'hFF, NUM_PIX + 1);
      end
      pulse_end();
      drain(1'b0);
      compare("R4 overflow");
      chk_eq("R4 ovf flag", mk_ovf, 1);
      chk_eq("R4 count full", mk_count, DEPTH);

      // R5 new train clears overflow
      pulse_start();
      chk_eq("R5 ovf cleared", int'(out_ovf), 0);
      add_hits(8'h04, 0);
      strobe(8'h04, NUM_PIX + 1);
      pulse_end();
      drain(1'b0);
      compare("R5 after overflow");

      // R9 train_start during readout
      pulse_start();
      add_hits(8'h01, 0);
      strobe(8'h01, NUM_PIX + 1);
      pulse_end();
      @(negedge clk);
      chk_eq("R9 readout active", int'(out_valid), 1);
      pulse_start();
      chk_eq("R9 seq_err set", int'(seq_err), 1);
      pulse_end();
      drain(1'b0);
      compare("R9 restarted train");
      chk_eq("R9 seq_err sticky", int'(seq_err), 1);

      // R2 long train: collision 14000 and saturation
      pulse_start();
      for (int k = 0; k < 14000; k++) strobe('0, 0);
      add_hits(8'h01, 14000);
      strobe(8'h01, NUM_PIX + 1);
      for (int k = 0; k < 2400; k++) strobe('0, 0);
      add_hits(8'h02, (1 << TS_W) - 1);
      strobe(8'h02, NUM_PIX + 1);
      pulse_end();
      drain(1'b0);
      compare("R2 long train");

      summary();
   end
endmodule